// File: doc/BRIEF.md
# Timer channel flag control unit

This block keeps the status and enable latches for every channel of a multi-channel timer coprocessor. Each channel has two match enables, two match event latches, two transition-detect latches, a request-inhibit latch and a continuous-capture enable. A decoded microinstruction arrives with a valid strobe. Its flag-control fields change the latches of the one channel named by the channel select, on the next clock edge.

The fields come in two formats. In the narrow format, a one-bit field clears a pair of latches at once. In the wide format, a two-bit field picks one latch, the other latch or both. Hardware match and transition pulses set the event latches of any channel at any time, whether or not a microinstruction is present. From the new latch values and the incoming link and host requests, the block builds a registered service-request vector per channel. The inhibit latch masks only the match and transition part of that vector.

Top module: `tfc_flag_ctrl`

## Requirements
- R1: Microcode-driven changes take effect on the rising edge at which `ui_valid` is 1, and only on channel `ch_sel`. With `ui_valid` at 0, or on any other channel, no enable, inhibit or capture latch changes.
- R2: Synchronous reset sets both match enables of every channel to 1. It sets every other latch and `srq_o` to 0.
- R3: Narrow format (`fmt_wide`=0) uses only bit 0 of `mdis_fld`: 0 clears both match enables and 1 leaves them unchanged. Bit 1 is ignored.
- R4: Wide format uses `mdis_fld` as follows. 00 clears match enable 1, 01 clears both, 10 clears match enable 2, and 11 changes nothing.
- R5: `menw1`/`menw2` at 1 set match enable 1/2, and 0 leaves it alone. A set in the same instruction as a disable wins.
- R6: Narrow format uses only bit 0 of `tclr_fld`: 0 clears both transition latches and 1 leaves them unchanged. Bit 1 is ignored.
- R7: Wide format uses `tclr_fld` as follows. 00 clears transition latch 1, 01 clears latch 2, 10 clears both, and 11 clears neither.
- R8: In either format, `mev1_keep`/`mev2_keep` at 0 clear match event latch 1/2, and 1 leaves it unchanged.
- R9: A hardware pulse sets its event latch on any channel without `ui_valid`, and beats a microcode clear of that latch in the same cycle. A match pulse sets its latch only if the match enable was 1 before that edge.
- R10: `rqd_fld` works as follows. 00 sets inhibit and clears capture enable, 01 sets inhibit only, 10 clears inhibit and sets capture enable, and 11 changes nothing.
- R11: At each edge, `srq_o[c]` takes the value ((new mev1|mev2|tdl1|tdl2) & ~new inhibit) | `lsr_in[c]` | `hsr_in[c]`. Link and host requests are never masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ui_valid | input | 1 | Microinstruction fields valid this cycle |
| ch_sel | input | CH_W (3) | Channel select register value |
| fmt_wide | input | 1 | 1 = two-bit field format, 0 = one-bit format |
| mdis_fld | input | 2 | Match-disable field |
| tclr_fld | input | 2 | Transition-clear field |
| mev1_keep | input | 1 | Match event 1 clear field, 0 clears |
| mev2_keep | input | 1 | Match event 2 clear field, 0 clears |
| menw1 | input | 1 | Match enable 1 write |
| menw2 | input | 1 | Match enable 2 write |
| rqd_fld | input | 2 | Request-disable field |
| hw_match1 | input | NUM_CH | Match 1 event pulses per channel |
| hw_match2 | input | NUM_CH | Match 2 event pulses per channel |
| hw_trans1 | input | NUM_CH | Transition 1 event pulses per channel |
| hw_trans2 | input | NUM_CH | Transition 2 event pulses per channel |
| lsr_in | input | NUM_CH | Link service requests |
| hsr_in | input | NUM_CH | Host service requests |
| men1_q | output | NUM_CH | Match enable 1 per channel |
| men2_q | output | NUM_CH | Match enable 2 per channel |
| mev1_q | output | NUM_CH | Match event latch 1 per channel |
| mev2_q | output | NUM_CH | Match event latch 2 per channel |
| tdl1_q | output | NUM_CH | Transition-detect latch 1 per channel |
| tdl2_q | output | NUM_CH | Transition-detect latch 2 per channel |
| inh_q | output | NUM_CH | Match/transition request-inhibit latch per channel |
| cap_q | output | NUM_CH | Continuous-capture enable per channel |
| srq_o | output | NUM_CH | Gated service-request vector |

## Verification
The case that needs care is a hardware event and a microcode clear of the same latch in the same cycle. The bench drives a match 2 pulse together with a cleared keep field, and a transition 1 pulse together with wide clear codes that target that latch. After the edge it expects the latch to read 1. A second case pairs an enable write with a wide disable of both enables. It also pairs a match pulse with an enable that is set only at that same edge. The first expects the written enable to be 1 and the other to be 0. The second expects the event latch to stay at 0.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

  // Per-instruction update strobes for one channel slice
  typedef struct packed {
    logic clr_men1;
    logic clr_men2;
    logic set_men1;
    logic set_men2;
    logic clr_mev1;
    logic clr_mev2;
    logic clr_tdl1;
    logic clr_tdl2;
    logic set_inh;
    logic clr_inh;
    logic set_cap;
    logic clr_cap;
  } tfc_ctl_t;

  // Wide match-disable codes
  localparam logic [1:0] MDIS_ONE  = 2'b00;
  localparam logic [1:0] MDIS_BOTH = 2'b01;
  localparam logic [1:0] MDIS_TWO  = 2'b10;

  // Wide transition-clear codes
  localparam logic [1:0] TCLR_ONE  = 2'b00;
  localparam logic [1:0] TCLR_TWO  = 2'b01;
  localparam logic [1:0] TCLR_BOTH = 2'b10;

  // Request-disable codes
  localparam logic [1:0] RQD_INH_NOCAP = 2'b00;
  localparam logic [1:0] RQD_INH       = 2'b01;
  localparam logic [1:0] RQD_UNINH_CAP = 2'b10;

endpackage

// File: rtl/tfc_decode.sv
module tfc_decode
  import tfc_pkg::*;
(
  input  logic       fmt_wide,
  input  logic [1:0] mdis_fld,
  input  logic [1:0] tclr_fld,
  input  logic       mev1_keep,
  input  logic       mev2_keep,
  input  logic       menw1,
  input  logic       menw2,
  input  logic [1:0] rqd_fld,
  output tfc_ctl_t   ctl
);

  always_comb begin
    ctl = '0;

    // match-enable disable
    if (fmt_wide) begin
      case (mdis_fld)
        MDIS_ONE:  ctl.clr_men1 = 1'b1;
        MDIS_BOTH: begin
          ctl.clr_men1 = 1'b1;
          ctl.clr_men2 = 1'b1;
        end
        MDIS_TWO:  ctl.clr_men2 = 1'b1;
        default:   ;
      endcase
    end else if (!mdis_fld[0]) begin
      ctl.clr_men1 = 1'b1;
      ctl.clr_men2 = 1'b1;
    end

    ctl.set_men1 = menw1;
    ctl.set_men2 = menw2;

    // transition latch clear
    if (fmt_wide) begin
      case (tclr_fld)
        TCLR_ONE:  ctl.clr_tdl1 = 1'b1;
        TCLR_TWO:  ctl.clr_tdl2 = 1'b1;
        TCLR_BOTH: begin
          ctl.clr_tdl1 = 1'b1;
          ctl.clr_tdl2 = 1'b1;
        end
        default:   ;
      endcase
    end else if (!tclr_fld[0]) begin
      ctl.clr_tdl1 = 1'b1;
      ctl.clr_tdl2 = 1'b1;
    end

    ctl.clr_mev1 = !mev1_keep;
    ctl.clr_mev2 = !mev2_keep;

    // request disable / capture enable
    case (rqd_fld)
      RQD_INH_NOCAP: begin
        ctl.set_inh = 1'b1;
        ctl.clr_cap = 1'b1;
      end
      RQD_INH:       ctl.set_inh = 1'b1;
      RQD_UNINH_CAP: begin
        ctl.clr_inh = 1'b1;
        ctl.set_cap = 1'b1;
      end
      default:       ;
    endcase
  end

endmodule

// File: rtl/tfc_srq_gate.sv
module tfc_srq_gate (
  input  logic [3:0] pend,
  input  logic       inh,
  input  logic       lsr,
  input  logic       hsr,
  output logic       req
);

  logic mt_req;

  always_comb begin
    mt_req = (|pend) & ~inh;
    req    = mt_req | lsr | hsr;
  end

endmodule

// File: rtl/tfc_slice.sv
module tfc_slice
  import tfc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hit,
  input  tfc_ctl_t ctl,
  input  logic     ev_m1,
  input  logic     ev_m2,
  input  logic     ev_t1,
  input  logic     ev_t2,
  input  logic     lsr,
  input  logic     hsr,
  output logic     men1_q,
  output logic     men2_q,
  output logic     mev1_q,
  output logic     mev2_q,
  output logic     tdl1_q,
  output logic     tdl2_q,
  output logic     inh_q,
  output logic     cap_q,
  output logic     srq_q
);

  logic men1_d, men2_d, mev1_d, mev2_d;
  logic tdl1_d, tdl2_d, inh_d, cap_d, srq_d;

  always_comb begin
    men1_d = men1_q;
    men2_d = men2_q;
    inh_d  = inh_q;
    cap_d  = cap_q;
    if (hit) begin
      men1_d = (men1_q & ~ctl.clr_men1) | ctl.set_men1;
      men2_d = (men2_q & ~ctl.clr_men2) | ctl.set_men2;
      if (ctl.set_inh)      inh_d = 1'b1;
      else if (ctl.clr_inh) inh_d = 1'b0;
      if (ctl.clr_cap)      cap_d = 1'b0;
      else if (ctl.set_cap) cap_d = 1'b1;
    end
    // hardware events take priority over microcode clears
    mev1_d = (ev_m1 & men1_q) | (mev1_q & ~(hit & ctl.clr_mev1));
    mev2_d = (ev_m2 & men2_q) | (mev2_q & ~(hit & ctl.clr_mev2));
    tdl1_d = ev_t1 | (tdl1_q & ~(hit & ctl.clr_tdl1));
    tdl2_d = ev_t2 | (tdl2_q & ~(hit & ctl.clr_tdl2));
  end

  tfc_srq_gate u_gate (
    .pend ({mev1_d, mev2_d, tdl1_d, tdl2_d}),
    .inh  (inh_d),
    .lsr  (lsr),
    .hsr  (hsr),
    .req  (srq_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      men1_q <= 1'b1;
      men2_q <= 1'b1;
      mev1_q <= 1'b0;
      mev2_q <= 1'b0;
      tdl1_q <= 1'b0;
      tdl2_q <= 1'b0;
      inh_q  <= 1'b0;
      cap_q  <= 1'b0;
      srq_q  <= 1'b0;
    end else begin
      men1_q <= men1_d;
      men2_q <= men2_d;
      mev1_q <= mev1_d;
      mev2_q <= mev2_d;
      tdl1_q <= tdl1_d;
      tdl2_q <= tdl2_d;
      inh_q  <= inh_d;
      cap_q  <= cap_d;
      srq_q  <= srq_d;
    end
  end

endmodule

// File: rtl/tfc_flag_ctrl.sv
module tfc_flag_ctrl
  import tfc_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ui_valid,
  input  logic [CH_W-1:0]   ch_sel,
  input  logic              fmt_wide,
  input  logic [1:0]        mdis_fld,
  input  logic [1:0]        tclr_fld,
  input  logic              mev1_keep,
  input  logic              mev2_keep,
  input  logic              menw1,
  input  logic              menw2,
  input  logic [1:0]        rqd_fld,
  input  logic [NUM_CH-1:0] hw_match1,
  input  logic [NUM_CH-1:0] hw_match2,
  input  logic [NUM_CH-1:0] hw_trans1,
  input  logic [NUM_CH-1:0] hw_trans2,
  input  logic [NUM_CH-1:0] lsr_in,
  input  logic [NUM_CH-1:0] hsr_in,
  output logic [NUM_CH-1:0] men1_q,
  output logic [NUM_CH-1:0] men2_q,
  output logic [NUM_CH-1:0] mev1_q,
  output logic [NUM_CH-1:0] mev2_q,
  output logic [NUM_CH-1:0] tdl1_q,
  output logic [NUM_CH-1:0] tdl2_q,
  output logic [NUM_CH-1:0] inh_q,
  output logic [NUM_CH-1:0] cap_q,
  output logic [NUM_CH-1:0] srq_o
);

  tfc_ctl_t          ctl;
  logic [NUM_CH-1:0] hit;

  tfc_decode u_dec (
    .fmt_wide  (fmt_wide),
    .mdis_fld  (mdis_fld),
    .tclr_fld  (tclr_fld),
    .mev1_keep (mev1_keep),
    .mev2_keep (mev2_keep),
    .menw1     (menw1),
    .menw2     (menw2),
    .rqd_fld   (rqd_fld),
    .ctl       (ctl)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign hit[g] = ui_valid && (ch_sel == CH_W'(g));

    tfc_slice u_slice (
      .clk    (clk),
      .rst    (rst),
      .hit    (hit[g]),
      .ctl    (ctl),
      .ev_m1  (hw_match1[g]),
      .ev_m2  (hw_match2[g]),
      .ev_t1  (hw_trans1[g]),
      .ev_t2  (hw_trans2[g]),
      .lsr    (lsr_in[g]),
      .hsr    (hsr_in[g]),
      .men1_q (men1_q[g]),
      .men2_q (men2_q[g]),
      .mev1_q (mev1_q[g]),
      .mev2_q (mev2_q[g]),
      .tdl1_q (tdl1_q[g]),
      .tdl2_q (tdl2_q[g]),
      .inh_q  (inh_q[g]),
      .cap_q  (cap_q[g]),
      .srq_q  (srq_o[g])
    );
  end

endmodule

// File: rtl/tfc_checker.sv
module tfc_checker #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              ui_valid,
  input logic [CH_W-1:0]   ch_sel,
  input logic              fmt_wide,
  input logic [1:0]        mdis_fld,
  input logic              menw1,
  input logic [1:0]        rqd_fld,
  input logic [NUM_CH-1:0] hw_match1,
  input logic [NUM_CH-1:0] lsr_in,
  input logic [NUM_CH-1:0] hsr_in,
  input logic [NUM_CH-1:0] men1_q,
  input logic [NUM_CH-1:0] men2_q,
  input logic [NUM_CH-1:0] mev1_q,
  input logic [NUM_CH-1:0] inh_q,
  input logic [NUM_CH-1:0] cap_q,
  input logic [NUM_CH-1:0] srq_o
);

  // R1: unselected channels keep their microcode-controlled latches
  for (genvar c = 0; c < NUM_CH; c++) begin : g_hold
    a_r1_other_ch_hold: assert property (@(posedge clk) disable iff (rst)
      !(ui_valid && ch_sel == CH_W'(c)) |=>
        ($stable(men1_q[c]) && $stable(men2_q[c]) &&
         $stable(inh_q[c]) && $stable(cap_q[c])));
  end

  // R3: narrow disable without a write clears match enable 1
  a_r3_narrow_disable: assert property (@(posedge clk) disable iff (rst)
    (ui_valid && !fmt_wide && !mdis_fld[0] && !menw1) |=>
      !men1_q[$past(ch_sel)]);

  // R9: an enabled match pulse always leaves its latch set
  a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
    ((hw_match1 & men1_q) != '0) |=>
      ((mev1_q & $past(hw_match1 & men1_q)) == $past(hw_match1 & men1_q)));

  // R10: code 01 leaves the inhibit latch set
  a_r10_inhibit_set: assert property (@(posedge clk) disable iff (rst)
    (ui_valid && rqd_fld == 2'b01) |=> inh_q[$past(ch_sel)]);

  // R11: link and host requests are never masked
  a_r11_link_host_pass: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((srq_o & $past(lsr_in | hsr_in)) == $past(lsr_in | hsr_in)));

  // R11: inhibited channels raise no match/transition request
  a_r11_inhibit_masks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((srq_o & inh_q & ~$past(lsr_in | hsr_in)) == '0));

endmodule

bind tfc_flag_ctrl tfc_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ui_valid  (ui_valid),
  .ch_sel    (ch_sel),
  .fmt_wide  (fmt_wide),
  .mdis_fld  (mdis_fld),
  .menw1     (menw1),
  .rqd_fld   (rqd_fld),
  .hw_match1 (hw_match1),
  .lsr_in    (lsr_in),
  .hsr_in    (hsr_in),
  .men1_q    (men1_q),
  .men2_q    (men2_q),
  .mev1_q    (mev1_q),
  .inh_q     (inh_q),
  .cap_q     (cap_q),
  .srq_o     (srq_o)
);

// File: tb/tb_tfc_flag_ctrl.sv
`timescale 1ns/1ps
module tb_tfc_flag_ctrl;

  localparam int NUM_CH = 8;
  localparam int CH_W   = 3;

  logic              clk = 1'b0;
  logic              rst;
  logic              ui_valid;
  logic [CH_W-1:0]   ch_sel;
  logic              fmt_wide;
  logic [1:0]        mdis_fld, tclr_fld, rqd_fld;
  logic              mev1_keep, mev2_keep, menw1, menw2;
  logic [NUM_CH-1:0] hw_match1, hw_match2, hw_trans1, hw_trans2;
  logic [NUM_CH-1:0] lsr_in, hsr_in;
  logic [NUM_CH-1:0] men1_q, men2_q, mev1_q, mev2_q;
  logic [NUM_CH-1:0] tdl1_q, tdl2_q, inh_q, cap_q, srq_o;

  always #2 clk = ~clk;

  tfc_flag_ctrl #(.NUM_CH(NUM_CH)) dut (.*);

  // stimulus: ch, wide, mdis, tclr, keep1, keep2, wr1, wr2, rqd, events {m1,m2,t1,t2}
  // expected: {men1, men2, mev1, mev2, tdl1, tdl2, inh, cap}
  typedef struct packed {
    logic [2:0] ch;
    logic       wide;
    logic [1:0] md;
    logic [1:0] tc;
    logic       k1;
    logic       k2;
    logic       e1;
    logic       e2;
    logic [1:0] rq;
    logic [3:0] ev;
    logic [7:0] ex;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t TBL [NV] = '{
    '{3'd2,1'b0,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b11,4'b1111,8'b11111100}, // R9 set all
    '{3'd2,1'b0,2'b11,2'b11,1'b0,1'b1,1'b0,1'b0,2'b11,4'b0000,8'b11011100}, // R8
    '{3'd2,1'b0,2'b11,2'b10,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0000,8'b11010000}, // R6
    '{3'd2,1'b0,2'b11,2'b11,1'b1,1'b0,1'b0,1'b0,2'b11,4'b0100,8'b11010000}, // R9 wins
    '{3'd2,1'b0,2'b10,2'b11,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0000,8'b00010000}, // R3
    '{3'd2,1'b0,2'b11,2'b11,1'b1,1'b0,1'b0,1'b0,2'b11,4'b1000,8'b00000000}, // R9 gated
    '{3'd2,1'b0,2'b11,2'b11,1'b1,1'b1,1'b1,1'b0,2'b11,4'b0000,8'b10000000}, // R5
    '{3'd2,1'b0,2'b11,2'b11,1'b1,1'b1,1'b0,1'b1,2'b11,4'b0000,8'b11000000}, // R5
    '{3'd2,1'b1,2'b00,2'b11,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0000,8'b01000000}, // R4
    '{3'd2,1'b1,2'b01,2'b11,1'b1,1'b1,1'b1,1'b0,2'b11,4'b0000,8'b10000000}, // R4 R5
    '{3'd2,1'b0,2'b11,2'b11,1'b1,1'b1,1'b0,1'b1,2'b11,4'b0000,8'b11000000}, // R5
    '{3'd2,1'b1,2'b10,2'b11,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0000,8'b10000000}, // R4
    '{3'd2,1'b1,2'b11,2'b11,1'b1,1'b1,1'b0,1'b1,2'b11,4'b0000,8'b11000000}, // R4 nop
    '{3'd2,1'b1,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b11,4'b1111,8'b11111100}, // R9
    '{3'd2,1'b1,2'b11,2'b00,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0000,8'b11110100}, // R7
    '{3'd2,1'b1,2'b11,2'b01,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0010,8'b11111000}, // R7
    '{3'd2,1'b1,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0001,8'b11111100}, // R7 nop
    '{3'd2,1'b1,2'b11,2'b10,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0000,8'b11110000}, // R7
    '{3'd2,1'b1,2'b11,2'b00,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0010,8'b11111000}, // R9 wins
    '{3'd2,1'b1,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b00,4'b0000,8'b11111010}, // R10
    '{3'd2,1'b1,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b10,4'b0000,8'b11111001}, // R10
    '{3'd2,1'b1,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b01,4'b0000,8'b11111011}, // R10
    '{3'd2,1'b1,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0000,8'b11111011}, // R10 nop
    '{3'd2,1'b1,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b00,4'b0000,8'b11111010}, // R10
    '{3'd2,1'b1,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b10,4'b0000,8'b11111001}, // R10
    '{3'd5,1'b0,2'b10,2'b11,1'b0,1'b0,1'b0,1'b0,2'b11,4'b0000,8'b00000000}, // R3
    '{3'd5,1'b0,2'b11,2'b11,1'b1,1'b1,1'b1,1'b1,2'b11,4'b1000,8'b11000000}, // R9 old enable
    '{3'd5,1'b1,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b11,4'b1000,8'b11100000}, // R9
    '{3'd5,1'b1,2'b11,2'b11,1'b0,1'b1,1'b0,1'b0,2'b11,4'b0000,8'b11000000}, // R8 wide
    '{3'd5,1'b0,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0011,8'b11001100}, // R9
    '{3'd5,1'b0,2'b11,2'b01,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0000,8'b11001100}, // R6 bit1 ignored
    '{3'd5,1'b0,2'b11,2'b00,1'b1,1'b1,1'b0,1'b0,2'b11,4'b0000,8'b11000000}  // R6
  };

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ui_valid = 1'b0; ch_sel = '0; fmt_wide = 1'b0;
    mdis_fld = 2'b11; tclr_fld = 2'b11; rqd_fld = 2'b11;
    mev1_keep = 1'b1; mev2_keep = 1'b1; menw1 = 1'b0; menw2 = 1'b0;
    hw_match1 = '0; hw_match2 = '0; hw_trans1 = '0; hw_trans2 = '0;
    lsr_in = '0; hsr_in = '0;
  endtask

  // drive at a falling edge, pass one rising edge, return at the next falling edge
  task automatic apply(input vec_t v);
    ui_valid = 1'b1; ch_sel = v.ch; fmt_wide = v.wide;
    mdis_fld = v.md; tclr_fld = v.tc; rqd_fld = v.rq;
    mev1_keep = v.k1; mev2_keep = v.k2; menw1 = v.e1; menw2 = v.e2;
    hw_match1 = NUM_CH'(v.ev[3]) << v.ch;
    hw_match2 = NUM_CH'(v.ev[2]) << v.ch;
    hw_trans1 = NUM_CH'(v.ev[1]) << v.ch;
    hw_trans2 = NUM_CH'(v.ev[0]) << v.ch;
    @(negedge clk);
    idle();
  endtask

  function automatic logic [7:0] state_of(input int c);
    return {men1_q[c], men2_q[c], mev1_q[c], mev2_q[c],
            tdl1_q[c], tdl2_q[c], inh_q[c], cap_q[c]};
  endfunction

  task automatic check_reset_state(input string tag);
    check({tag, " R2 men1"}, 32'(men1_q), 32'hFF);
    check({tag, " R2 men2"}, 32'(men2_q), 32'hFF);
    check({tag, " R2 latches"},
          32'(mev1_q | mev2_q | tdl1_q | tdl2_q | inh_q | cap_q), 32'h0);
    check({tag, " R2 srq"}, 32'(srq_o), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state("start");

    // table walk on the selected channel
    for (int i = 0; i < NV; i++) begin
      logic exp_srq;
      apply(TBL[i]);
      exp_srq = (|TBL[i].ex[5:2]) & ~TBL[i].ex[1];
      check($sformatf("vec %0d R1/R3-R10 state", i), 32'(state_of(int'(TBL[i].ch))),
            32'(TBL[i].ex));
      check($sformatf("vec %0d R11 srq", i), 32'(srq_o[TBL[i].ch]), 32'(exp_srq));
    end

    // R1: channel 2 untouched by channel 5 work, channel 7 still at reset
    check("R1 ch2 kept", 32'(state_of(2)), 32'(8'b11111001));
    check("R1 ch7 untouched", 32'(state_of(7)), 32'(8'b11000000));

    // R1: fields that would clear everything, but ui_valid low
    ch_sel = 3'd2; mdis_fld = 2'b00; tclr_fld = 2'b00; rqd_fld = 2'b00;
    mev1_keep = 1'b0; mev2_keep = 1'b0;
    @(negedge clk);
    idle();
    check("R1 no valid", 32'(state_of(2)), 32'(8'b11111001));

    // R11: pending match on ch2, inhibit off -> request
    check("R11 pending passes", 32'(srq_o[2]), 32'd1);
    apply('{3'd2,1'b1,2'b11,2'b11,1'b1,1'b1,1'b0,1'b0,2'b01,4'b0000,8'h00});
    check("R11 inhibited", 32'(srq_o[2]), 32'd0);
    lsr_in[2] = 1'b1;
    @(negedge clk);
    idle();
    check("R11 link passes inhibit", 32'(srq_o[2]), 32'd1);
    hsr_in[2] = 1'b1;
    @(negedge clk);
    idle();
    check("R11 host passes inhibit", 32'(srq_o[2]), 32'd1);
    @(negedge clk);
    check("R11 masked again", 32'(srq_o[2]), 32'd0);

    // R9: hardware event on an unselected channel, no microinstruction
    hw_trans1[7] = 1'b1;
    @(negedge clk);
    idle();
    check("R9 event ch7 tdl1", 32'(tdl1_q[7]), 32'd1);
    check("R9 event ch7 srq", 32'(srq_o[7]), 32'd1);
    check("R1 ch7 enables", 32'({men1_q[7], men2_q[7], inh_q[7]}), 32'(3'b110));

    // R2: reset in the middle of a run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_reset_state("mid");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule